// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked host and an external asynchronous static RAM. The RAM is made of four byte-wide lanes, each with 512K locations. The host presents one request at a time: a byte address, write data, a byte mask and a read/write flag. The controller turns that request into a timed sequence of chip selects, per-lane write enables, a shared output enable and a tri-state data bus. When the transfer ends it pulses `done` for one cycle, and for reads it returns the captured word.

The phase lengths are whole clock cycles set by parameters. These are address setup before the write pulse, write pulse width, data hold after the pulse, and read access. With the default values a 10 ns clock meets the RAM's access and pulse limits.

A build-time width parameter chooses how the four lanes are grouped:
- as one 32-bit bank,
- as two 16-bit banks, or
- as four 8-bit banks.

The grouping decides which host address bits reach the RAM address, which bits pick the bank, and where read data lands in the returned word.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, and in the first idle cycle after it, every chip select, write enable and output enable is high (inactive), `done` is 0 and `req_ready` is 1. Asserting reset in the middle of a transfer forces the strobes inactive at once, without waiting for a clock edge.
- R2: A request is taken only at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 exactly when the controller is idle. A request presented while a transfer is in progress has no effect on the RAM contents.
- R3: A write runs through three phases:
  - For SU_CYC cycles the selected chip selects are low, the address is valid and all write enables are high.
  - Then the write enables of the written lanes are low for WE_CYC cycles.
  - Then all write enables are high for HD_CYC cycles, with the data still driven.
  Output enable stays high for the whole write.
- R4: In the 32-bit grouping, all four chip selects go low together. Lane i carries data bits [8i+7:8i], and its write enable pulses only if `req_mask[i]` is 1. The RAM address is host address bits [20:2].
- R5: A read holds the chip selects low for RD_CYC cycles. Output enable is high in the first of those cycles and low in the rest. The bus is sampled at the clock edge that ends the last read cycle.
- R6: `done` is high for exactly one cycle, the cycle right after the last cycle of the transfer. On that cycle `rdata` holds the word returned by a read.
- R7: The controller drives the data bus only during the three write phases. Output enable never goes low in a cycle that directly follows a cycle in which the bus was driven.
- R8: In the 16-bit grouping:
  - Host address bit 20 selects the bank: 0 selects lanes 0 and 1, and 1 selects lanes 2 and 3. The other pair's chip selects stay high.
  - The RAM address is host bits [19:1].
  - `req_mask[1:0]` enables the two lanes, and write data comes from `req_wdata[15:0]`.
  - Read data is returned in `rdata[15:0]`, with the upper half zero.
- R9: In the 8-bit grouping:
  - Host address bits [20:19] select one lane, and only that lane's chip select goes low.
  - The RAM address is host bits [18:0].
  - Only `req_mask[0]` enables the write; if it is 0 the location keeps its value. Write data comes from `req_wdata[7:0]`.
  - Read data is returned in `rdata[7:0]`, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Host byte address |
| req_wdata | input | 32 | Host write data |
| req_mask | input | 4 | Byte enables for a write |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rdata | output | 32 | Registered read data |
| ram_addr | output | 19 | RAM address |
| ram_cs_n | output | 4 | Per-lane chip selects, active low |
| ram_we_n | output | 4 | Per-lane write enables, active low |
| ram_oe_n | output | 1 | Shared output enable, active low |
| ram_dq | inout | 32 | Tri-state RAM data bus |

## Verification
The hardest case to reach from the ports is a request that arrives while a transfer is already running. The bench starts a read and then holds a conflicting full-word write on the request inputs through the busy cycles. It checks that `req_ready` stays low. It then drops the request before the controller goes idle, so the write is never taken, and reads the location again to show that its contents were not changed. The bench also raises reset during the write pulse and samples the strobes before the next clock edge, to show that the reset acts asynchronously. Three instances, one per grouping, run the same stimulus against a lane-accurate RAM model. Per-cycle strobe expectations are computed for each grouping.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  localparam int LANES = 4;

  typedef enum logic [1:0] {
    BUSW_32 = 2'd0,
    BUSW_16 = 2'd1,
    BUSW_8  = 2'd2
  } busw_e;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_WSETUP = 3'd1,
    PH_WPULSE = 3'd2,
    PH_WHOLD  = 3'd3,
    PH_READ   = 3'd4
  } phase_e;

endpackage

// File: rtl/sram_lane_map.sv
module sram_lane_map
  import sram_ctrl_pkg::*;
#(
  parameter busw_e MODE    = BUSW_32,
  parameter int    RADDR_W = 19,
  parameter int    LANE_W  = 8,
  localparam int   DATA_W  = LANE_W * LANES,
  localparam int   HADDR_W = RADDR_W + 2
) (
  input  logic [HADDR_W-1:0] haddr,
  input  logic [LANES-1:0]   hmask,
  input  logic [DATA_W-1:0]  hwdata,
  input  logic [HADDR_W-1:0] rd_haddr,
  input  logic [DATA_W-1:0]  lane_rdata,
  output logic [RADDR_W-1:0] ram_addr,
  output logic [LANES-1:0]   cs_sel,
  output logic [LANES-1:0]   we_sel,
  output logic [DATA_W-1:0]  wbus,
  output logic [DATA_W-1:0]  rword
);

  if (MODE == BUSW_32) begin : g_w32
    logic unused_map;
    assign unused_map = ^{haddr[1:0], rd_haddr};
    assign ram_addr = haddr[RADDR_W+1:2];
    assign cs_sel   = '1;
    assign we_sel   = hmask;
    assign wbus     = hwdata;
    assign rword    = lane_rdata;
  end else if (MODE == BUSW_16) begin : g_w16
    localparam int HALF_W = DATA_W / 2;
    logic bank, rbank;
    logic unused_map;
    assign unused_map = ^{haddr[0], rd_haddr[RADDR_W:0], hmask[3:2], hwdata[DATA_W-1:HALF_W]};
    assign bank     = haddr[RADDR_W+1];
    assign rbank    = rd_haddr[RADDR_W+1];
    assign ram_addr = haddr[RADDR_W:1];
    assign cs_sel   = {{2{bank}}, {2{~bank}}};
    assign we_sel   = cs_sel & {hmask[1:0], hmask[1:0]};
    assign wbus     = {2{hwdata[HALF_W-1:0]}};
    assign rword    = {{HALF_W{1'b0}},
                       (rbank ? lane_rdata[DATA_W-1:HALF_W] : lane_rdata[HALF_W-1:0])};
  end else begin : g_w8
    logic [1:0] bank, rbank;
    logic unused_map;
    assign unused_map = ^{rd_haddr[RADDR_W-1:0], hmask[3:1], hwdata[DATA_W-1:LANE_W]};
    assign bank     = haddr[RADDR_W+1:RADDR_W];
    assign rbank    = rd_haddr[RADDR_W+1:RADDR_W];
    assign ram_addr = haddr[RADDR_W-1:0];
    assign cs_sel   = LANES'(1) << bank;
    assign we_sel   = cs_sel & {LANES{hmask[0]}};
    assign wbus     = {LANES{hwdata[LANE_W-1:0]}};
    assign rword    = {{(DATA_W-LANE_W){1'b0}}, lane_rdata[LANE_W*rbank +: LANE_W]};
  end

endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
  import sram_ctrl_pkg::*;
#(
  parameter int SU_CYC = 1,
  parameter int WE_CYC = 2,
  parameter int HD_CYC = 1,
  parameter int RD_CYC = 3,
  localparam int MAX_A = (SU_CYC > WE_CYC) ? SU_CYC : WE_CYC,
  localparam int MAX_B = (HD_CYC > RD_CYC) ? HD_CYC : RD_CYC,
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int CNT_W = $clog2(MAX_C + 1)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   start_wr,
  output phase_e phase_q,
  output phase_e phase_d,
  output logic   rd_oe_d,
  output logic   fin
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q + CNT_W'(1);
    fin     = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (start) phase_d = start_wr ? PH_WSETUP : PH_READ;
      end
      PH_WSETUP: if (cnt_q == CNT_W'(SU_CYC - 1)) begin
        phase_d = PH_WPULSE;
        cnt_d   = '0;
      end
      PH_WPULSE: if (cnt_q == CNT_W'(WE_CYC - 1)) begin
        phase_d = PH_WHOLD;
        cnt_d   = '0;
      end
      PH_WHOLD: if (cnt_q == CNT_W'(HD_CYC - 1)) begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
        fin     = 1'b1;
      end
      PH_READ: if (cnt_q == CNT_W'(RD_CYC - 1)) begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
        fin     = 1'b1;
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
    rd_oe_d = (phase_d == PH_READ) && (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  // R3: a transfer starts only from idle, as a write setup or a read
  p_entry_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |=> (phase_q inside {PH_IDLE, PH_WSETUP, PH_READ}));

  // R3: the write pulse is always followed by the hold phase
  p_pulse_then_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WPULSE && phase_d != PH_WPULSE) |=> (phase_q == PH_WHOLD));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter busw_e MODE    = BUSW_32,
  parameter int    RADDR_W = 19,
  parameter int    LANE_W  = 8,
  parameter int    SU_CYC  = 1,
  parameter int    WE_CYC  = 2,
  parameter int    HD_CYC  = 1,
  parameter int    RD_CYC  = 3,
  localparam int   DATA_W  = LANE_W * LANES,
  localparam int   HADDR_W = RADDR_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [HADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [LANES-1:0]   req_mask,
  output logic               done,
  output logic [DATA_W-1:0]  rdata,
  output logic [RADDR_W-1:0] ram_addr,
  output logic [LANES-1:0]   ram_cs_n,
  output logic [LANES-1:0]   ram_we_n,
  output logic               ram_oe_n,
  inout  wire  [DATA_W-1:0]  ram_dq
);

  phase_e phase_q, phase_d;
  logic   rd_oe_d, fin, accept, capture;

  logic [HADDR_W-1:0] addr_q;
  logic [RADDR_W-1:0] raddr_q, map_raddr;
  logic [LANES-1:0]   cs_sel_q, we_sel_q, map_cs, map_we, cs_sel_nx, we_sel_nx;
  logic [DATA_W-1:0]  wbus_q, map_wbus, map_rword, rdata_q, rdata_d;
  logic [LANES-1:0]   cs_n_q, cs_n_d, we_n_q, we_n_d;
  logic               oe_n_q, oe_n_d, drv_q, drv_d, done_q;

  sram_phase_seq #(
    .SU_CYC(SU_CYC), .WE_CYC(WE_CYC), .HD_CYC(HD_CYC), .RD_CYC(RD_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_wr(req_write),
    .phase_q(phase_q), .phase_d(phase_d), .rd_oe_d(rd_oe_d), .fin(fin)
  );

  sram_lane_map #(.MODE(MODE), .RADDR_W(RADDR_W), .LANE_W(LANE_W)) u_map (
    .haddr(req_addr), .hmask(req_mask), .hwdata(req_wdata),
    .rd_haddr(addr_q), .lane_rdata(ram_dq),
    .ram_addr(map_raddr), .cs_sel(map_cs), .we_sel(map_we),
    .wbus(map_wbus), .rword(map_rword)
  );

  assign req_ready = (phase_q == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign capture   = fin && (phase_q == PH_READ);

  always_comb begin
    cs_sel_nx = accept ? map_cs : cs_sel_q;
    we_sel_nx = accept ? map_we : we_sel_q;
    cs_n_d    = (phase_d == PH_IDLE) ? '1 : ~cs_sel_nx;
    we_n_d    = (phase_d == PH_WPULSE) ? ~we_sel_nx : '1;
    oe_n_d    = ~rd_oe_d;
    drv_d     = phase_d inside {PH_WSETUP, PH_WPULSE, PH_WHOLD};
    rdata_d   = capture ? map_rword : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      raddr_q  <= '0;
      cs_sel_q <= '0;
      we_sel_q <= '0;
      wbus_q   <= '0;
      cs_n_q   <= '1;
      we_n_q   <= '1;
      oe_n_q   <= 1'b1;
      drv_q    <= 1'b0;
      done_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (accept) begin
        addr_q   <= req_addr;
        raddr_q  <= map_raddr;
        cs_sel_q <= map_cs;
        we_sel_q <= map_we;
        wbus_q   <= map_wbus;
      end
      cs_n_q  <= cs_n_d;
      we_n_q  <= we_n_d;
      oe_n_q  <= oe_n_d;
      drv_q   <= drv_d;
      done_q  <= fin;
      rdata_q <= rdata_d;
    end
  end

  assign ram_addr = raddr_q;
  assign ram_cs_n = cs_n_q;
  assign ram_we_n = we_n_q;
  assign ram_oe_n = oe_n_q;
  assign ram_dq   = drv_q ? wbus_q : 'z;
  assign done     = done_q;
  assign rdata    = rdata_q;

  // R3: a lane's write enable is only low while its chip select is low
  p_we_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((~ram_we_n & ram_cs_n) == '0));

  // R3: output enable stays high whenever any write enable is low
  p_oe_quiet_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we_n != '1) |-> ram_oe_n);

  // R3: the address is stable and chip select already low when a pulse starts
  p_addr_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we_n != '1 && $past(ram_we_n) == '1) |->
      ($stable(ram_addr) && $past(ram_cs_n) != '1));

  // R7: output enable never falls straight after a cycle of driving the bus
  p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_oe_n) |-> !$past(drv_q));

  // R7: the bus is never driven while the RAM outputs are enabled
  p_no_fight_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> ram_oe_n);

  // R6: done lasts a single cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: while busy at least one chip select is active
  p_busy_selects_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (ram_cs_n != '1));

  if (MODE == BUSW_16) begin : g_chk16
    // R8: only whole lane pairs are selected
    p_pair_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_cs_n == 4'b1111) || (ram_cs_n == 4'b1100) || (ram_cs_n == 4'b0011));
  end else if (MODE == BUSW_8) begin : g_chk8
    // R9: at most one lane selected
    p_one_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~ram_cs_n) <= 1);
  end

endmodule

// File: tb/test_sram_async_ctrl.sv
module sram_lane_model (
  input  logic        clk,
  input  logic [18:0] addr,
  input  logic [3:0]  cs_n,
  input  logic [3:0]  we_n,
  input  logic        oe_n,
  inout  wire  [31:0] dq
);
  for (genvar i = 0; i < 4; i++) begin : g_lane
    logic [7:0] mem [16];
    initial for (int k = 0; k < 16; k++) mem[k] = 8'h00;
    assign dq[8*i +: 8] = (!cs_n[i] && we_n[i] && !oe_n) ? mem[addr[3:0]] : 8'bz;
    always @(negedge clk) if (!cs_n[i] && !we_n[i]) mem[addr[3:0]] <= dq[8*i +: 8];
  end
endmodule

module test_sram_async_ctrl;
  import sram_ctrl_pkg::*;

  localparam int SU = 1, WE = 2, HD = 1, RD = 3;

  logic        clk, rst_n, req_valid, req_write;
  logic [20:0] req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_mask;

  logic        t_ready [3];
  logic        t_done  [3];
  logic [31:0] t_rdata [3];
  logic [18:0] t_raddr [3];
  logic [3:0]  t_cs_n  [3];
  logic [3:0]  t_we_n  [3];
  logic        t_oe_n  [3];
  wire  [95:0] dq_all;

  int total = 0, bad = 0;
  bit ended = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  for (genvar g = 0; g < 3; g++) begin : g_dut
    localparam busw_e M = (g == 0) ? BUSW_32 : (g == 1) ? BUSW_16 : BUSW_8;
    if (g == 0) begin : g_main
      sram_async_ctrl #(.MODE(M)) i_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(t_ready[g]),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .done(t_done[g]), .rdata(t_rdata[g]),
        .ram_addr(t_raddr[g]), .ram_cs_n(t_cs_n[g]), .ram_we_n(t_we_n[g]),
        .ram_oe_n(t_oe_n[g]), .ram_dq(dq_all[32*g +: 32]));
    end else begin : g_narrow
      sram_async_ctrl #(.MODE(M)) i_sram_async_ctrl_n (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(t_ready[g]),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .done(t_done[g]), .rdata(t_rdata[g]),
        .ram_addr(t_raddr[g]), .ram_cs_n(t_cs_n[g]), .ram_we_n(t_we_n[g]),
        .ram_oe_n(t_oe_n[g]), .ram_dq(dq_all[32*g +: 32]));
    end
    sram_lane_model u_ram (.clk(clk), .addr(t_raddr[g]), .cs_n(t_cs_n[g]),
      .we_n(t_we_n[g]), .oe_n(t_oe_n[g]), .dq(dq_all[32*g +: 32]));
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] f_cs(int g, logic [20:0] a);
    if (g == 0) return 4'hF;
    if (g == 1) return a[20] ? 4'hC : 4'h3;
    return 4'b0001 << a[20:19];
  endfunction

  function automatic logic [3:0] f_we(int g, logic [20:0] a, logic [3:0] m);
    if (g == 0) return m;
    if (g == 1) return f_cs(g, a) & {m[1:0], m[1:0]};
    return f_cs(g, a) & {4{m[0]}};
  endfunction

  function automatic logic [18:0] f_ra(int g, logic [20:0] a);
    if (g == 0) return a[20:2];
    if (g == 1) return a[19:1];
    return a[18:0];
  endfunction

  // One transfer on all three instances; ce selects which rdata are checked
  task automatic run_op(input bit wr, input logic [20:0] a, input logic [31:0] d,
                        input logic [3:0] m, input logic [2:0] ce,
                        input logic [31:0] e0, input logic [31:0] e1, input logic [31:0] e2);
    int n;
    logic [31:0] ex [3];
    ex[0] = e0; ex[1] = e1; ex[2] = e2;
    n = wr ? (SU + WE + HD) : RD;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    for (int g = 0; g < 3; g++) chk(t_ready[g] == 1'b1, "R2 ready when idle", 32'(t_ready[g]), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < n; c++) begin
      for (int g = 0; g < 3; g++) begin
        logic [3:0] ecs, ewe;
        logic       eoe;
        ecs = ~f_cs(g, a);
        ewe = (wr && c >= SU && c < SU + WE) ? ~f_we(g, a, m) : 4'hF;
        eoe = (!wr && c >= 1) ? 1'b0 : 1'b1;
        chk(t_cs_n[g] == ecs, (g == 0) ? "R4 chip selects" : (g == 1) ? "R8 chip selects" : "R9 chip selects",
            32'(t_cs_n[g]), 32'(ecs));
        chk(t_we_n[g] == ewe, wr ? "R3 write enable timing" : "R5 no write enable in read",
            32'(t_we_n[g]), 32'(ewe));
        chk(t_oe_n[g] == eoe, wr ? "R3 oe high in write" : "R5 oe timing", 32'(t_oe_n[g]), 32'(eoe));
        chk(t_ready[g] == 1'b0, "R2 busy not ready", 32'(t_ready[g]), 32'd0);
        chk(t_done[g] == 1'b0, "R6 no early done", 32'(t_done[g]), 32'd0);
        if (c == 0) chk(t_raddr[g] == f_ra(g, a), "R4 R8 R9 ram address", 32'(t_raddr[g]), 32'(f_ra(g, a)));
      end
      @(negedge clk);
    end
    for (int g = 0; g < 3; g++) begin
      chk(t_done[g] == 1'b1, "R6 done after transfer", 32'(t_done[g]), 32'd1);
      chk(t_cs_n[g] == 4'hF, "R6 strobes idle at done", 32'(t_cs_n[g]), 32'hF);
      if (!wr && ce[g]) chk(t_rdata[g] == ex[g], (g == 0) ? "R5 read data" : (g == 1) ? "R8 read data" : "R9 read data",
                            t_rdata[g], ex[g]);
    end
    @(negedge clk);
    for (int g = 0; g < 3; g++) chk(t_done[g] == 1'b0, "R6 done one cycle", 32'(t_done[g]), 32'd0);
  endtask

  typedef struct packed {
    logic        wr;
    logic [20:0] a;
    logic [31:0] d;
    logic [3:0]  m;
    logic [31:0] e;
  } vec_t;

  // R4 R5: 32-bit grouping, word and partial-byte writes then reads
  localparam vec_t VEC [8] = '{
    '{1'b1, 21'h000010, 32'h11223344, 4'hF, 32'h0},
    '{1'b0, 21'h000010, 32'h0,        4'h0, 32'h11223344},
    '{1'b1, 21'h000010, 32'hAABBCCDD, 4'h5, 32'h0},
    '{1'b0, 21'h000010, 32'h0,        4'h0, 32'h11BB33DD},
    '{1'b1, 21'h000024, 32'h0F0E0D0C, 4'hC, 32'h0},
    '{1'b0, 21'h000024, 32'h0,        4'h0, 32'h0F0E0000},
    '{1'b1, 21'h1FFFFC, 32'hDEADBEEF, 4'hF, 32'h0},
    '{1'b0, 21'h1FFFFC, 32'h0,        4'h0, 32'hDEADBEEF}
  };

  initial begin
    #(20 * 100000);
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_mask = '0;
    repeat (3) @(negedge clk);
    for (int g = 0; g < 3; g++) begin
      chk(t_cs_n[g] == 4'hF && t_we_n[g] == 4'hF && t_oe_n[g] == 1'b1, "R1 strobes in reset",
          {t_cs_n[g], t_we_n[g], 3'b0, t_oe_n[g]}, 32'hFF1);
      chk(t_done[g] == 1'b0, "R1 done in reset", 32'(t_done[g]), 32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int g = 0; g < 3; g++)
      chk(t_ready[g] == 1'b1 && t_cs_n[g] == 4'hF, "R1 idle after reset",
          {27'b0, t_ready[g], t_cs_n[g]}, 32'h1F);

    for (int i = 0; i < 8; i++)
      run_op(VEC[i].wr, VEC[i].a, VEC[i].d, VEC[i].m, 3'b001, VEC[i].e, 32'h0, 32'h0);

    // R2: a write held on the request inputs while a read is busy is ignored
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 21'h000010; req_mask = 4'h0;
    @(negedge clk);
    req_write = 1'b1; req_wdata = 32'h55555555; req_mask = 4'hF;
    chk(t_ready[0] == 1'b0, "R2 busy during read", 32'(t_ready[0]), 32'd0);
    @(negedge clk);
    chk(t_ready[0] == 1'b0, "R2 busy during read", 32'(t_ready[0]), 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(t_ready[0] == 1'b0, "R2 busy during read", 32'(t_ready[0]), 32'd0);
    @(negedge clk);
    chk(t_done[0] == 1'b1 && t_rdata[0] == 32'h11BB33DD, "R2 first read result", t_rdata[0], 32'h11BB33DD);
    run_op(1'b0, 21'h000010, 32'h0, 4'h0, 3'b001, 32'h11BB33DD, 32'h0, 32'h0);

    // R8: two 16-bit banks, independent contents, byte write in upper bank
    run_op(1'b1, 21'h000004, 32'h0000A1B2, 4'h3, 3'b000, 0, 0, 0);
    run_op(1'b1, 21'h100004, 32'h0000C3D4, 4'h3, 3'b000, 0, 0, 0);
    run_op(1'b0, 21'h000004, 32'h0, 4'h0, 3'b010, 0, 32'h0000A1B2, 0);
    run_op(1'b0, 21'h100004, 32'h0, 4'h0, 3'b010, 0, 32'h0000C3D4, 0);
    run_op(1'b1, 21'h100004, 32'h0000EE00, 4'h2, 3'b000, 0, 0, 0);
    run_op(1'b0, 21'h100004, 32'h0, 4'h0, 3'b010, 0, 32'h0000EED4, 0);

    // R9: four byte banks, then a write with mask bit 0 clear leaves data alone
    for (int b = 0; b < 4; b++)
      run_op(1'b1, (21'(b) << 19) | 21'h5, 32'(8'h10 + b), 4'h1, 3'b000, 0, 0, 0);
    for (int b = 0; b < 4; b++)
      run_op(1'b0, (21'(b) << 19) | 21'h5, 32'h0, 4'h0, 3'b100, 0, 0, 32'(8'h10 + b));
    run_op(1'b1, (21'd2 << 19) | 21'h5, 32'h00000077, 4'hE, 3'b000, 0, 0, 0);
    run_op(1'b0, (21'd2 << 19) | 21'h5, 32'h0, 4'h0, 3'b100, 0, 0, 32'h12);

    // R1: reset during the write pulse releases strobes without a clock edge
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 21'h000030; req_wdata = 32'h1; req_mask = 4'hF;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(t_we_n[0] == 4'h0, "R3 pulse before reset", 32'(t_we_n[0]), 32'h0);
    #3 rst_n = 1'b0;
    #1;
    for (int g = 0; g < 3; g++)
      chk(t_cs_n[g] == 4'hF && t_we_n[g] == 4'hF && t_oe_n[g] == 1'b1, "R1 async reset",
          {t_cs_n[g], t_we_n[g], 3'b0, t_oe_n[g]}, 32'hFF1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(t_ready[0] == 1'b1, "R1 ready after reset", 32'(t_ready[0]), 32'd1);

    ended = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule